// File: doc/BRIEF.md
# Disk Controller Host Register File

This block holds the registers that host software uses to drive a cartridge-disk controller over a 16-bit word-addressed I/O bus. It decodes five word registers at byte offsets 0, 2, 4, 6 and 8 from its base:

- the control/status word;
- the memory address for transfers;
- the disk address;
- a multipurpose register, which is a word count when written and a status FIFO when read;
- a six-bit address extension.

The host starts a command by writing the control word with the ready bit clear. The register file then gives the function code to an internal sequencer with a one-cycle start pulse. It waits for a done or error strobe, and it sets the ready bit again when one arrives.

The status word combines three things: the sequencer's error code, a live drive-error line and a live drive-ready line. Its top bit is a summary error flag. An interrupt request is latched when a command finishes with interrupts enabled, and it is held until acknowledged. A debug-mode input protects the host: after a command completes in debug mode, the next register read returns zero. The synchronous bus-initialise input and the active-low reset bring the block to the same idle state.

Top module: `dkc_regfile`

## Requirements
- R1: Registers decode at byte offsets 0 (control/status), 2 (memory address), 4 (disk address), 6 (multipurpose) and 8 (extension, bits 5:0). Any other offset reads 0, and a write to any other offset changes no register.
- R2: The control/status word reads as follows:
  - bit 0: drive_ready;
  - bits 3:1: function code;
  - bits 5:4: extension bits 1:0;
  - bit 6: interrupt enable;
  - bit 7: ready;
  - bits 9:8: drive select;
  - bits 13:10: error code;
  - bit 14: drive_err;
  - bit 15: summary error.
- R3: A write to the control/status word changes only bits 1 to 9. Written values of bits 0 and 10 to 15 have no effect.
- R4: While ready is 1, a control/status write with bit 7 = 0 clears ready. In the next cycle seq_start pulses for one cycle with seq_func equal to the written bits 3:1. The host can never set ready. Ready returns to 1 only on seq_done, on seq_err, or on initialisation.
- R5: The error code is cleared when a command starts. A seq_err strobe while busy loads seq_err_code into bits 13:10.
- R6: Reset or bus_init clears these fields:
  - control/status bits 1 to 6 and 8 to 13;
  - the memory address, the disk address and the word count;
  - the extension register and the interrupt request.

  It also sets ready. The control/status word then reads 0x0080 plus drive_ready in bit 0.
- R7: Control/status bits 5:4 and extension bits 1:0 are one storage. A write through either address is read back identically through both.
- R8: Bit 15 is 1 exactly when bits 14:10 are not all zero.
- R9: If ready rises while debug_mode is 1, the next register read returns 0x0000. The read after that returns normal data.
- R10: The word count written at offset 6 appears only on word_count. A read at offset 6 returns the oldest word pushed by stat_push and removes it, in first-in first-out order. A read of an empty FIFO returns 0.
- R11: While ready is 0, host writes to every register are ignored.
- R12: irq is set when ready rises with interrupt enable 1. It stays set even if interrupt enable is cleared later, and irq_ack clears it. No request is raised when interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_init | input | 1 | Synchronous bus initialise |
| debug_mode | input | 1 | Host in debug mode; enables zero-read protection |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Byte offset of register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data (combinational) |
| seq_start | output | 1 | One-cycle command start pulse |
| seq_func | output | 3 | Function code of the command |
| seq_done | input | 1 | Command completed strobe |
| seq_err | input | 1 | Command ended with error strobe |
| seq_err_code | input | 4 | Error code accompanying seq_err |
| drive_ready | input | 1 | Selected drive ready |
| drive_err | input | 1 | Selected drive error |
| stat_push | input | 1 | Push a word into the read FIFO |
| stat_word | input | 16 | Word to push |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| mem_addr | output | 16 | Memory address register |
| disk_addr | output | 16 | Disk address register |
| word_count | output | 16 | Word count register |
| addr_ext | output | 6 | Address extension bits |
| drive_sel | output | 2 | Drive select |

## Verification
A wrong ready state shows up in two ways. The host sees bit 7 wrong on the very next read, and writes are then accepted or dropped wrongly, which the memory-address readback exposes. A lost or duplicated start pulse is visible on seq_start one cycle after the command write. A mismatch between the two aliased copies of address bits 16 and 17 appears on the first read of the other address. A FIFO pointer error shows up as out-of-order or stale words at offset 6, and a stuck zero-read flag blanks every following read.

// File: rtl/dkc_regfile.sv
module dkc_regfile #(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_init,
  input  logic        debug_mode,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [3:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        seq_start,
  output logic [2:0]  seq_func,
  input  logic        seq_done,
  input  logic        seq_err,
  input  logic [3:0]  seq_err_code,
  input  logic        drive_ready,
  input  logic        drive_err,
  input  logic        stat_push,
  input  logic [15:0] stat_word,
  output logic        irq,
  input  logic        irq_ack,
  output logic [15:0] mem_addr,
  output logic [15:0] disk_addr,
  output logic [15:0] word_count,
  output logic [5:0]  addr_ext,
  output logic [1:0]  drive_sel
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic        init;
  logic        crdy, ie, zero_rd;
  logic [2:0]  func;
  logic [3:0]  errc;
  logic [15:0] csr_word, reg_word;
  logic [15:0] fifo_mem [FIFO_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic        wr_ok, start_cmd, done_evt, push, pop;

  assign init      = !rst_n || bus_init;
  assign wr_ok     = host_wr && crdy;
  assign start_cmd = wr_ok && host_addr == 4'd0 && !host_wdata[7];
  assign done_evt  = !crdy && (seq_done || seq_err);
  assign push      = stat_push && cnt != CW'(FIFO_DEPTH);
  assign pop       = host_rd && host_addr == 4'd6 && !zero_rd && cnt != '0;
  assign seq_func  = func;

  assign csr_word = {(|errc) | drive_err, drive_err, errc, drive_sel, crdy, ie,
                     addr_ext[1:0], func, drive_ready};

  always_comb begin
    case (host_addr)
      4'd0:    reg_word = csr_word;
      4'd2:    reg_word = mem_addr;
      4'd4:    reg_word = disk_addr;
      4'd6:    reg_word = (cnt != '0) ? fifo_mem[rp] : 16'h0000;
      4'd8:    reg_word = {10'b0, addr_ext};
      default: reg_word = 16'h0000;
    endcase
  end
  assign host_rdata = zero_rd ? 16'h0000 : reg_word;

  always_ff @(posedge clk) begin
    if (init) begin
      crdy <= 1'b1; ie <= 1'b0; func <= '0; errc <= '0; drive_sel <= '0;
      mem_addr <= '0; disk_addr <= '0; word_count <= '0; addr_ext <= '0;
      irq <= 1'b0; zero_rd <= 1'b0; seq_start <= 1'b0;
    end else begin
      seq_start <= start_cmd;
      if (wr_ok) begin
        case (host_addr)
          4'd0: begin
            func <= host_wdata[3:1];
            addr_ext[1:0] <= host_wdata[5:4];
            ie <= host_wdata[6];
            drive_sel <= host_wdata[9:8];
            if (!host_wdata[7]) begin
              crdy <= 1'b0;
              errc <= '0;
            end
          end
          4'd2: mem_addr <= host_wdata;
          4'd4: disk_addr <= host_wdata;
          4'd6: word_count <= host_wdata;
          4'd8: addr_ext <= host_wdata[5:0];
          default: ;
        endcase
      end
      if (done_evt) begin
        crdy <= 1'b1;
        if (seq_err) errc <= seq_err_code;
      end
      if (done_evt && ie) irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      if (done_evt && debug_mode) zero_rd <= 1'b1;
      else if (host_rd) zero_rd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) begin
        fifo_mem[wp] <= stat_word;
        wp <= (wp == PW'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  AST_READY_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!crdy && !seq_done && !seq_err && !bus_init) |=> !crdy); // R4
  AST_START_CLEAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (errc == 4'd0 && !crdy)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && !bus_init) |=> irq); // R12
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !crdy && !bus_init) |=> ($stable(mem_addr) && $stable(disk_addr)
      && $stable(word_count) && $stable(addr_ext))); // R11
  AST_SUMMARY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 4'd0 && !zero_rd) |->
      (host_rdata[15] == (|host_rdata[14:10]))); // R8
endmodule

// File: tb/sim_dkc_regfile.sv
module sim_dkc_regfile;
  logic clk = 0, rst_n = 0, bus_init = 0, debug_mode = 0;
  logic host_wr = 0, host_rd = 0;
  logic [3:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic seq_start, seq_done = 0, seq_err = 0;
  logic [2:0] seq_func;
  logic [3:0] seq_err_code = 0;
  logic drive_ready = 0, drive_err = 0, stat_push = 0, irq, irq_ack = 0;
  logic [15:0] stat_word = 0, mem_addr, disk_addr, word_count;
  logic [5:0] addr_ext;
  logic [1:0] drive_sel;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] d;

  always #2 clk = ~clk;

  dkc_regfile #(.FIFO_DEPTH(4)) u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = v;
    @(posedge clk); #1 host_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); host_rd = 1; host_addr = a; #1 v = host_rdata;
    @(posedge clk); #1 host_rd = 0;
  endtask

  task automatic pulse_done(input logic err, input logic [3:0] code);
    @(negedge clk); seq_done = !err; seq_err = err; seq_err_code = code;
    @(posedge clk); #1 seq_done = 0; seq_err = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    drive_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0, d); chk("R6 reset csr", d, 16'h0081);
    rd(2, d); chk("R6 reset mem_addr", d, 0);
    rd(6, d); chk("R10 empty fifo", d, 0);

    // R2 R3 sweep of writable control fields
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < 4; e++)
        for (int ie = 0; ie < 2; ie++)
          for (int ds = 0; ds < 4; ds++) begin
            drive_ready = f[0];
            wr(0, {6'h3F, ds[1:0], 1'b1, ie[0], e[1:0], f[2:0], 1'b1});
            rd(0, d);
            chk("R2 R3 csr fields", d, {6'b0, ds[1:0], 1'b1, ie[0], e[1:0], f[2:0], f[0]});
            rd(8, d); chk("R7 ext from csr", d, {14'b0, e[1:0]});
          end
    drive_ready = 1;
    wr(0, 16'h0080);

    // R7 sweep through the extension register
    for (int v = 0; v < 64; v++) begin
      wr(8, 16'hFFC0 | 16'(v));
      rd(0, d); chk("R7 csr from ext", {14'b0, d[5:4]}, 16'(v & 3));
      rd(8, d); chk("R7 ext readback", d, 16'(v));
      chk("R7 addr_ext port", {10'b0, addr_ext}, 16'(v));
    end
    wr(8, 0);

    // R1 decode
    for (int k = 0; k < 16; k++) begin
      wr(2, 16'h1 << k); rd(2, d); chk("R1 mem_addr", d, 16'h1 << k);
      wr(4, ~(16'h1 << k)); rd(4, d); chk("R1 disk_addr", d, ~(16'h1 << k));
    end
    for (int a = 10; a < 16; a++) begin
      wr(4'(a), 16'hDEAD);
      rd(4'(a), d); chk("R1 unused offset reads 0", d, 0);
    end
    wr(1, 16'h7777); wr(3, 16'h7777); wr(9, 16'h7777);
    rd(2, d); chk("R1 mem_addr untouched", d, 16'h8000);
    rd(4, d); chk("R1 disk_addr untouched", d, 16'h7FFF);
    rd(8, d); chk("R1 ext untouched", d, 0);

    // R10 word count and FIFO
    wr(6, 16'h1234);
    chk("R10 word_count port", word_count, 16'h1234);
    rd(6, d); chk("R10 wc not readable", d, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); stat_push = 1; stat_word = 16'hA000 + 16'(i);
      @(posedge clk); #1 stat_push = 0;
    end
    for (int i = 0; i < 4; i++) begin
      rd(6, d); chk("R10 fifo order", d, 16'hA000 + 16'(i));
    end
    rd(6, d); chk("R10 fifo drained", d, 0);

    // R4 R11 R12 command handshake
    wr(2, 16'h0100);
    wr(0, 16'h0046);
    chk("R4 start pulse", {15'b0, seq_start}, 1);
    chk("R4 start func", {13'b0, seq_func}, 3);
    @(posedge clk); #1 chk("R4 single pulse", {15'b0, seq_start}, 0);
    rd(0, d); chk("R4 busy csr", d, 16'h0047);
    wr(2, 16'hFFFF); wr(4, 16'hFFFF); wr(8, 16'h003F);
    wr(0, 16'h00C0);
    rd(0, d); chk("R4 host cannot set ready", d, 16'h0047);
    rd(2, d); chk("R11 mem_addr ignored busy", d, 16'h0100);
    rd(4, d); chk("R11 disk_addr ignored busy", d, 16'h7FFF);
    rd(8, d); chk("R11 ext ignored busy", d, 0);
    chk("R12 no irq while busy", {15'b0, irq}, 0);
    pulse_done(0, 0);
    rd(0, d); chk("R4 ready after done", d, 16'h00C7);
    chk("R12 irq raised", {15'b0, irq}, 1);
    wr(0, 16'h0080);
    chk("R12 irq held after ie cleared", {15'b0, irq}, 1);
    @(negedge clk); irq_ack = 1; @(posedge clk); #1 irq_ack = 0;
    chk("R12 irq acked", {15'b0, irq}, 0);

    // R5 R8 error-code sweep
    for (int c = 0; c < 16; c++) begin
      wr(0, 16'h0002);
      rd(0, d); chk("R5 code cleared at start", d, 16'h0003);
      pulse_done(1, 4'(c));
      rd(0, d);
      chk("R5 R8 error code", d, {(c != 0), 1'b0, 4'(c), 10'h083});
    end
    chk("R12 no irq with ie 0", {15'b0, irq}, 0);
    drive_err = 1;
    rd(0, d); chk("R8 drive error", d[15:14], 2'b11);
    wr(0, 16'h0002); pulse_done(0, 0);
    rd(0, d); chk("R8 drive error only", d, 16'hC083);
    drive_err = 0;
    rd(0, d); chk("R8 no error", d, 16'h0083);

    // R9 zero read after ready rises in debug mode
    debug_mode = 1;
    wr(2, 16'h4321);
    wr(0, 16'h0000); pulse_done(0, 0);
    rd(2, d); chk("R9 first read zero", d, 0);
    rd(2, d); chk("R9 second read normal", d, 16'h4321);
    debug_mode = 0;

    // R6 bus initialise
    wr(0, 16'h033E); wr(4, 16'h5555); wr(6, 16'h9999); wr(8, 16'h002A);
    wr(0, 16'h0060);
    @(negedge clk); bus_init = 1; @(posedge clk); #1 bus_init = 0;
    rd(0, d); chk("R6 init csr", d, 16'h0081);
    rd(2, d); chk("R6 init mem_addr", d, 0);
    rd(4, d); chk("R6 init disk_addr", d, 0);
    rd(8, d); chk("R6 init ext", d, 0);
    chk("R6 init word_count", word_count, 0);
    chk("R6 init drive_sel", {14'b0, drive_sel}, 0);
    chk("R6 init no start", {15'b0, seq_start}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule